// File: doc/BRIEF.md
# Packet Number Status Queues

This block keeps two short queues of packet numbers for a network controller. The receive queue lists packets that have arrived and wait for the host. The transmit queue lists packets whose transmission has finished and whose status the host has yet to collect. Hardware on the MAC side loads a number into either queue with a one-cycle push strobe.

The host sees both queue heads through one 16-bit read-only status word. Reading the word has no side effect. The receive head leaves its queue only on a remove command, which has two variants. The transmit head leaves its queue only on a transmit interrupt acknowledge. Each byte of the word is laid out so that, while its empty flag is clear, the host can write the byte unchanged into its packet number register. Two level interrupt status outputs follow queue occupancy. Each queue also has a sticky overflow flag.

Top module: `pktnum_status_fifos`

## Requirements
- R1: After reset both queues are empty, `status_word` reads 16'h8080, and `rx_int`, `tx_int`, `rx_ovf` and `tx_ovf` are all 0.
- R2: Layout of `status_word`:
  - Bit 15 is the receive empty flag, bit 14 reads 0, and bits 13:8 hold the receive head number.
  - Bit 7 is the transmit empty flag, bit 6 reads 0, and bits 5:0 hold the transmit head number.
  - An empty flag is 1 exactly when its queue holds no entries, and the number field of an empty queue reads 0.
- R3: Each queue holds up to 4 six-bit numbers and presents them at its head in the order they were pushed. A push becomes visible in `status_word` one clock after the edge that samples it.
- R4: A push into a queue that already holds 4 entries is dropped, even when a pop happens in the same cycle. The drop sets that queue's overflow output, which stays 1 until reset.
- R5: A pop request on an empty queue is ignored. If a push arrives in the same cycle, the pushed number becomes the head.
- R6: Either `rx_remove_a` or `rx_remove_b` pops one receive entry. Both asserted together still pop exactly one entry.
- R7: The queues are independent. Receive removes never change the transmit byte or `tx_ovf`. `tx_int_ack` never changes the receive byte or `rx_ovf`.
- R8: `rx_int` is 1 exactly when the receive queue is non-empty. `tx_int` is 1 exactly when the transmit queue is non-empty.
- R9: A push and a pop in the same cycle on a queue that is non-empty and not full leave the entry count unchanged and advance the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Load `rx_push_num` into the receive queue |
| rx_push_num | input | 6 | Packet number for the receive queue |
| tx_push | input | 1 | Load `tx_push_num` into the transmit queue |
| tx_push_num | input | 6 | Packet number for the transmit queue |
| rx_remove_a | input | 1 | Host remove command, first variant; pops the receive head |
| rx_remove_b | input | 1 | Host remove command, second variant; pops the receive head |
| tx_int_ack | input | 1 | Host transmit interrupt acknowledge; pops the transmit head |
| status_word | output | 16 | Packed heads and empty flags of both queues |
| rx_int | output | 1 | Receive queue non-empty |
| tx_int | output | 1 | Transmit queue non-empty |
| rx_ovf | output | 1 | Sticky receive overflow |
| tx_ovf | output | 1 | Sticky transmit overflow |

## Verification
The directed part fills the receive queue past its depth with distinct numbers. It then drains the queue with each remove variant alone and with both together. This separates true first-in first-out order from an off-by-one head, and one pop from a double pop. Pops on empty queues and pushes paired with pops on empty, partly filled and full queues separate the four cases of the count update. The directed part also shows that a full-queue push is dropped even when a pop happens in the same cycle.

A long pseudo-random sweep then drives all sixteen combinations of push and pop strobes on both queues, using varied numbers. After every cycle it compares the whole status word, both interrupts and both overflow flags with an arithmetic queue model. Any crosstalk between the two queues or any stale number in an empty field shows up there.

// File: rtl/pnq_pkg.sv
`timescale 1ns/1ps
package pnq_pkg;
    localparam int STAT_BYTE_W = 8;
    localparam int STAT_W      = 2 * STAT_BYTE_W;

    // One byte of the host status word: flag on top, number below
    typedef struct packed {
        logic                   empty;
        logic [STAT_BYTE_W-2:0] field;
    } pnq_byte_t;
endpackage

// File: rtl/pnq_queue.sv
`timescale 1ns/1ps
module pnq_queue #(
    parameter int DEPTH = 4,
    parameter int NUM_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [NUM_W-1:0] push_num,
    input  logic             pop,
    output logic [NUM_W-1:0] head_num,
    output logic             empty,
    output logic             overflow
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][NUM_W-1:0] mem;
        logic [PTR_W-1:0]            wr;
        logic [PTR_W-1:0]            rd;
        logic [CNT_W-1:0]            cnt;
        logic                        ovf;
    } q_state_t;

    q_state_t s_d, s_q;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    logic full_w, empty_w, push_ok, pop_ok;

    always_comb begin
        s_d     = s_q;
        full_w  = (s_q.cnt == CNT_W'(DEPTH));
        empty_w = (s_q.cnt == '0);
        push_ok = push && !full_w;
        pop_ok  = pop && !empty_w;

        if (push && full_w) begin
            s_d.ovf = 1'b1;
        end
        if (push_ok) begin
            s_d.mem[s_q.wr] = push_num;
            s_d.wr          = ptr_next(s_q.wr);
        end
        if (pop_ok) begin
            s_d.rd = ptr_next(s_q.rd);
        end
        case ({push_ok, pop_ok})
            2'b10:   s_d.cnt = s_q.cnt + CNT_W'(1);
            2'b01:   s_d.cnt = s_q.cnt - CNT_W'(1);
            default: s_d.cnt = s_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign head_num = s_q.mem[s_q.rd];
    assign empty    = (s_q.cnt == '0);
    assign overflow = s_q.ovf;
endmodule

// File: rtl/pnq_status_pack.sv
`timescale 1ns/1ps
module pnq_status_pack #(
    parameter int NUM_W = 6
) (
    input  logic                       rx_empty,
    input  logic [NUM_W-1:0]           rx_head,
    input  logic                       tx_empty,
    input  logic [NUM_W-1:0]           tx_head,
    output logic [pnq_pkg::STAT_W-1:0] word
);
    localparam int PAD_W = pnq_pkg::STAT_BYTE_W - 1 - NUM_W;

    pnq_pkg::pnq_byte_t rx_b, tx_b;

    always_comb begin
        rx_b.empty = rx_empty;
        rx_b.field = rx_empty ? '0 : {{PAD_W{1'b0}}, rx_head};
        tx_b.empty = tx_empty;
        tx_b.field = tx_empty ? '0 : {{PAD_W{1'b0}}, tx_head};
        word       = {rx_b, tx_b};
    end
endmodule

// File: rtl/pktnum_status_fifos.sv
`timescale 1ns/1ps
module pktnum_status_fifos #(
    parameter int DEPTH = 4,
    parameter int NUM_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       rx_push,
    input  logic [NUM_W-1:0]           rx_push_num,
    input  logic                       tx_push,
    input  logic [NUM_W-1:0]           tx_push_num,
    input  logic                       rx_remove_a,
    input  logic                       rx_remove_b,
    input  logic                       tx_int_ack,
    output logic [pnq_pkg::STAT_W-1:0] status_word,
    output logic                       rx_int,
    output logic                       tx_int,
    output logic                       rx_ovf,
    output logic                       tx_ovf
);
    logic             rx_pop;
    logic             rx_empty, tx_empty;
    logic [NUM_W-1:0] rx_head, tx_head;

    assign rx_pop = rx_remove_a | rx_remove_b;

    pnq_queue #(.DEPTH(DEPTH), .NUM_W(NUM_W)) u_rx_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (rx_push),
        .push_num (rx_push_num),
        .pop      (rx_pop),
        .head_num (rx_head),
        .empty    (rx_empty),
        .overflow (rx_ovf)
    );

    pnq_queue #(.DEPTH(DEPTH), .NUM_W(NUM_W)) u_tx_q (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (tx_push),
        .push_num (tx_push_num),
        .pop      (tx_int_ack),
        .head_num (tx_head),
        .empty    (tx_empty),
        .overflow (tx_ovf)
    );

    pnq_status_pack #(.NUM_W(NUM_W)) u_pack (
        .rx_empty (rx_empty),
        .rx_head  (rx_head),
        .tx_empty (tx_empty),
        .tx_head  (tx_head),
        .word     (status_word)
    );

    assign rx_int = !rx_empty;
    assign tx_int = !tx_empty;
endmodule

// File: rtl/pnq_checker.sv
`timescale 1ns/1ps
module pnq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        rx_push,
    input logic        tx_push,
    input logic        rx_remove_a,
    input logic        rx_remove_b,
    input logic        tx_int_ack,
    input logic [15:0] status_word,
    input logic        rx_int,
    input logic        tx_int,
    input logic        rx_ovf,
    input logic        tx_ovf
);
    a_r8_rx_int: assert property (@(posedge clk) disable iff (!rst_n)
        rx_int == !status_word[15]);
    a_r8_tx_int: assert property (@(posedge clk) disable iff (!rst_n)
        tx_int == !status_word[7]);
    a_r2_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[14] && !status_word[6]);
    a_r2_rx_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[15] |-> status_word[14:8] == 7'd0);
    a_r2_tx_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[7] |-> status_word[6:0] == 7'd0);
    a_r4_rx_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf |=> rx_ovf);
    a_r4_tx_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovf |=> tx_ovf);
    a_r5_rx_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[15] && !rx_push |=> status_word[15]);
    a_r5_tx_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[7] && !tx_push |=> status_word[7]);
    a_r7_rx_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_push && !rx_remove_a && !rx_remove_b |=> $stable(status_word[15:8]));
    a_r7_tx_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_push && !tx_int_ack |=> $stable(status_word[7:0]));
endmodule

bind pktnum_status_fifos pnq_checker u_pnq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_push     (rx_push),
    .tx_push     (tx_push),
    .rx_remove_a (rx_remove_a),
    .rx_remove_b (rx_remove_b),
    .tx_int_ack  (tx_int_ack),
    .status_word (status_word),
    .rx_int      (rx_int),
    .tx_int      (tx_int),
    .rx_ovf      (rx_ovf),
    .tx_ovf      (tx_ovf)
);

// File: tb/pktnum_status_fifos_bench.sv
`timescale 1ns/1ps
module pktnum_status_fifos_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        rx_push, tx_push, rx_remove_a, rx_remove_b, tx_int_ack;
    logic [5:0]  rx_push_num, tx_push_num;
    logic [15:0] status_word;
    logic        rx_int, tx_int, rx_ovf, tx_ovf;

    always #2.5 clk = ~clk;

    pktnum_status_fifos u_pktnum_status_fifos (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_push_num(rx_push_num),
        .tx_push(tx_push), .tx_push_num(tx_push_num),
        .rx_remove_a(rx_remove_a), .rx_remove_b(rx_remove_b),
        .tx_int_ack(tx_int_ack), .status_word(status_word),
        .rx_int(rx_int), .tx_int(tx_int), .rx_ovf(rx_ovf), .tx_ovf(tx_ovf)
    );

    int total = 0;
    int fails = 0;

    // Queue model: index 0 = receive, 1 = transmit
    logic [5:0] mq [2][4];
    int         mn [2];
    bit         mo [2];

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int k = 0; k < 2; k++) begin
            mn[k] = 0;
            mo[k] = 0;
            for (int i = 0; i < 4; i++) mq[k][i] = '0;
        end
    endtask

    task automatic model_step(input int k, input bit push, input logic [5:0] num,
                              input bit pop);
        int oldn;
        oldn = mn[k];
        if (pop && oldn > 0) begin
            for (int i = 0; i < 3; i++) mq[k][i] = mq[k][i+1];
            mn[k] = mn[k] - 1;
        end
        if (push) begin
            if (oldn < 4) begin
                mq[k][mn[k]] = num;
                mn[k] = mn[k] + 1;
            end else begin
                mo[k] = 1;
            end
        end
    endtask

    function automatic logic [7:0] exp_byte(input int k);
        return (mn[k] == 0) ? 8'h80 : {2'b00, mq[k][0]};
    endfunction

    task automatic check_all(input string req);
        chk(req, "status_word", {16'h0, status_word}, {16'h0, exp_byte(0), exp_byte(1)});
        chk(req, "rx_int", {31'h0, rx_int}, {31'h0, (mn[0] != 0)});
        chk(req, "tx_int", {31'h0, tx_int}, {31'h0, (mn[1] != 0)});
        chk(req, "rx_ovf", {31'h0, rx_ovf}, {31'h0, mo[0]});
        chk(req, "tx_ovf", {31'h0, tx_ovf}, {31'h0, mo[1]});
    endtask

    // Called at a negative edge; applies one cycle of strobes
    task automatic step(input bit rp, input logic [5:0] rn, input bit ra, input bit rb,
                        input bit tp, input logic [5:0] tn, input bit ta);
        rx_push = rp; rx_push_num = rn; rx_remove_a = ra; rx_remove_b = rb;
        tx_push = tp; tx_push_num = tn; tx_int_ack = ta;
        @(posedge clk);
        model_step(0, rp, rn, ra | rb);
        model_step(1, tp, tn, ta);
        @(negedge clk);
        rx_push = 0; rx_remove_a = 0; rx_remove_b = 0; tx_push = 0; tx_int_ack = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        rst_n = 0;
        rx_push = 0; tx_push = 0; rx_remove_a = 0; rx_remove_b = 0; tx_int_ack = 0;
        rx_push_num = '0; tx_push_num = '0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1", "status_word", {16'h0, status_word}, 32'h8080);
        check_all("R1");

        // R3, R4: fill receive queue, fifth push overflows
        step(1, 6'h11, 0, 0, 0, 0, 0); check_all("R3");
        step(1, 6'h22, 0, 0, 0, 0, 0); check_all("R3");
        step(1, 6'h33, 0, 0, 0, 0, 0); check_all("R3");
        step(1, 6'h3F, 0, 0, 0, 0, 0);
        chk("R4", "rx_ovf before overflow", {31'h0, rx_ovf}, 32'h0);
        step(1, 6'h05, 0, 0, 0, 0, 0);
        chk("R4", "rx_ovf after overflow", {31'h0, rx_ovf}, 32'h1);
        chk("R2", "status_word full", {16'h0, status_word}, 32'h1180);
        // R7, R5: transmit ack on empty tx leaves rx alone
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R7", "status_word", {16'h0, status_word}, 32'h1180);
        check_all("R5");
        // R6: each remove variant, then both together
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R6", "head after remove_a", {16'h0, status_word}, 32'h2280);
        step(0, 0, 0, 1, 0, 0, 0);
        chk("R6", "head after remove_b", {16'h0, status_word}, 32'h3380);
        step(0, 0, 1, 1, 0, 0, 0);
        chk("R6", "head after both removes", {16'h0, status_word}, 32'h3F80);
        // R4: full-queue push with pop is dropped
        step(1, 6'h01, 0, 0, 0, 0, 0);
        step(1, 6'h02, 0, 0, 0, 0, 0);
        step(1, 6'h03, 0, 0, 0, 0, 0);
        step(1, 6'h04, 1, 0, 0, 0, 0); check_all("R4");
        step(0, 0, 1, 0, 0, 0, 0);
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R4", "dropped push never appears", {16'h0, status_word}, 32'h0380);
        step(0, 0, 1, 0, 0, 0, 0);
        chk("R8", "rx_int when empty", {31'h0, rx_int}, 32'h0);
        step(0, 0, 1, 1, 0, 0, 0);
        chk("R5", "pop on empty rx", {16'h0, status_word}, 32'h8080);
        chk("R4", "rx_ovf sticky", {31'h0, rx_ovf}, 32'h1);
        chk("R7", "tx_ovf untouched", {31'h0, tx_ovf}, 32'h0);

        // R9, R5, R8 on the transmit queue
        step(0, 0, 0, 0, 1, 6'h07, 1);
        chk("R5", "push with pop on empty tx", {16'h0, status_word}, 32'h8007);
        step(0, 0, 0, 0, 1, 6'h2A, 0);
        step(0, 0, 0, 0, 1, 6'h15, 1);
        chk("R9", "head advanced", {16'h0, status_word}, 32'h802A);
        chk("R8", "tx_int", {31'h0, tx_int}, 32'h1);
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R9", "count kept", {16'h0, status_word}, 32'h8015);
        step(0, 0, 0, 0, 0, 0, 1);
        chk("R8", "tx_int empty", {31'h0, tx_int}, 32'h0);
        check_all("R7");

        // R3, R2, R8: pseudo-random sweep against the model
        lfsr = 16'hACE1;
        for (int c = 0; c < 3000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[0], lfsr[6:1] ^ 6'(c), lfsr[7] & lfsr[8], lfsr[9] & lfsr[8],
                 lfsr[10], lfsr[15:10] + 6'(c), lfsr[11]);
            check_all("R3");
        end

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule